// File: doc/BRIEF.md
# Dual-Lane Burst Memory Data Path

This block is a small synthesizable model of a memory array and its burst data path on a 32-bit bus. The bus is split into a lower 16-bit lane (bits 15..0) and an upper 16-bit lane (bits 31..16). Each lane has its own column address, and both lanes share one bank and the row that is open in that bank. Activate and precharge requests keep track of which row, if any, is open in each bank. A read or write that targets a bank with no open row is refused and raises an error pulse.

Each column of a lane holds a 16-beat segment. In QDR mode, one access moves the whole segment as a 16-beat burst, which is 512 bits across both lanes. In DDR mode, one access moves an 8-beat burst, which is 256 bits, and a half-select bit picks either the first or the second half of the segment. The beat order is fixed and always ascending. Because of this, data written in one mode can be read back in the other: one QDR burst maps onto two DDR bursts, and two DDR bursts map onto one QDR burst. Write beats go into the array one per cycle. Read beats come out one per cycle on a 32-bit output.

Top module: `dual_lane_burst_mem`

## Requirements
- R1: After reset, `rvalid`, `busy` and `err` are 0, `rdata` is 0, and every bank is closed.
- R2: A read or write issued while idle to a bank with no open row is refused. `err` is 1 for exactly the next cycle, no burst starts, and the array keeps its contents. `act_req` opens bank `bank` at row `row`, and `pre_req` closes bank `bank`.
- R3: In QDR mode (`qdr_mode`=1), a write takes 16 beats on `wdata`. The first beat is the one presented in the `wr_req` cycle. A read returns the 16 beats of the segment in ascending order.
- R4: In DDR mode (`qdr_mode`=0), a burst is 8 beats. With `half_sel`=0 it covers segment beats 0..7, and with `half_sel`=1 it covers beats 8..15.
- R5: In QDR mode, `half_sel` has no effect on the data that is read or written.
- R6: `col_lo` selects the segment for `rdata`/`wdata` bits 15..0, and `col_hi` selects the segment for bits 31..16. The two lanes use the same bank and that bank's open row.
- R7: A segment written by one 16-beat QDR burst reads back as two 8-beat DDR bursts (half 0, then half 1). A segment written by two DDR bursts reads back as one QDR burst.
- R8: Read and write requests that arrive while `busy` is 1 are ignored. They do not change the array, do not disturb the running burst, and do not raise `err`.
- R9: An access uses the row given by the most recent activate of the target bank. A new activate without a precharge switches that bank to the new row.
- R10: The first read beat appears on `rdata` the cycle after `rd_req`. `rvalid` is then 1 for exactly the burst length (16 in QDR, 8 in DDR). `rdata` is 0 whenever `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qdr_mode | input | 1 | 1 = 16-beat bursts, 0 = 8-beat bursts; sampled when a burst is accepted |
| act_req | input | 1 | Open row `row` in bank `bank` |
| pre_req | input | 1 | Close bank `bank` |
| rd_req | input | 1 | Start a read burst |
| wr_req | input | 1 | Start a write burst; `wdata` carries beat 0 in this cycle |
| bank | input | 2 | Bank for every request |
| row | input | 2 | Row for activate |
| col_lo | input | 2 | Column of the lower lane |
| col_hi | input | 2 | Column of the upper lane |
| half_sel | input | 1 | DDR half of the segment: 0 = beats 0..7, 1 = beats 8..15 |
| wdata | input | 32 | Write beat |
| rdata | output | 32 | Read beat, 0 when not valid |
| rvalid | output | 1 | Read beat valid |
| busy | output | 1 | A burst is in progress and new read/write requests are ignored |
| err | output | 1 | Pulse: the previous request targeted a closed bank |

## Verification
Some properties are checked on every cycle by the assertions. The length of each `rvalid` run must match the mode captured when the read was accepted. Every error pulse must follow a request and must not coincide with any burst activity. Every read burst must begin right after an accepted read request. Other behaviour can only be shown by the bench's scenarios, because it depends on the array contents. This covers lane independence, the half-select mapping, QDR/DDR interchange of the same data, row switching on re-activate, and the fact that requests made while busy leave no trace. For these, the bench compares each beat against its own model of the array.

// File: rtl/dual_lane_burst_mem.sv
module dual_lane_burst_mem #(
  parameter int BANKS  = 4,
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int LANE_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         qdr_mode,
  input  logic                         act_req,
  input  logic                         pre_req,
  input  logic                         rd_req,
  input  logic                         wr_req,
  input  logic [$clog2(BANKS)-1:0]     bank,
  input  logic [$clog2(ROWS)-1:0]      row,
  input  logic [$clog2(COLS)-1:0]      col_lo,
  input  logic [$clog2(COLS)-1:0]      col_hi,
  input  logic                         half_sel,
  input  logic [2*LANE_W-1:0]          wdata,
  output logic [2*LANE_W-1:0]          rdata,
  output logic                         rvalid,
  output logic                         busy,
  output logic                         err
);
  localparam int BA_W  = $clog2(BANKS);
  localparam int RA_W  = $clog2(ROWS);
  localparam int CA_W  = $clog2(COLS);
  localparam int SEG   = 16;
  localparam int POS_W = $clog2(SEG);
  localparam int DEPTH = BANKS * ROWS * COLS * SEG;
  localparam int IDX_W = BA_W + RA_W + CA_W + POS_W;

  logic [BANKS-1:0] open_q;
  logic [RA_W-1:0]  open_row_q [BANKS];
  logic [LANE_W-1:0] mem_lo [DEPTH];
  logic [LANE_W-1:0] mem_hi [DEPTH];

  logic             rd_act, wr_act, mode_q, half_q, err_q;
  logic [POS_W-1:0] cnt;
  logic [BA_W-1:0]  bank_q;
  logic [RA_W-1:0]  row_q;
  logic [CA_W-1:0]  cl_q, ch_q;

  wire idle  = !rd_act && !wr_act;
  wire hit   = open_q[bank];
  wire do_wr = wr_req && !act_req && !pre_req && idle;
  wire do_rd = rd_req && !act_req && !pre_req && !wr_req && idle;
  wire wr_go = do_wr && hit;
  wire rd_go = do_rd && hit;

  wire [BA_W-1:0]  s_bank = idle ? bank : bank_q;
  wire [RA_W-1:0]  s_row  = idle ? open_row_q[bank] : row_q;
  wire [CA_W-1:0]  s_cl   = idle ? col_lo : cl_q;
  wire [CA_W-1:0]  s_ch   = idle ? col_hi : ch_q;
  wire             s_mode = idle ? qdr_mode : mode_q;
  wire             s_half = idle ? half_sel : half_q;
  wire [POS_W-1:0] beat   = idle ? '0 : cnt;
  wire [POS_W-1:0] pos    = s_mode ? beat : {s_half, beat[POS_W-2:0]};
  wire [POS_W-1:0] last   = mode_q ? POS_W'(SEG - 1) : POS_W'(SEG / 2 - 1);

  wire [IDX_W-1:0] idx_lo = {s_bank, s_row, s_cl, pos};
  wire [IDX_W-1:0] idx_hi = {s_bank, s_row, s_ch, pos};

  always_ff @(posedge clk) begin
    if (wr_go || wr_act) begin
      mem_lo[idx_lo] <= wdata[LANE_W-1:0];
      mem_hi[idx_hi] <= wdata[2*LANE_W-1:LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= '0;
      for (int i = 0; i < BANKS; i++) open_row_q[i] <= '0;
      rd_act <= 1'b0;
      wr_act <= 1'b0;
      cnt    <= '0;
      mode_q <= 1'b0;
      half_q <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      cl_q   <= '0;
      ch_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= (do_wr || do_rd) && !hit;
      if (act_req) begin
        open_q[bank]     <= 1'b1;
        open_row_q[bank] <= row;
      end else if (pre_req) begin
        open_q[bank] <= 1'b0;
      end
      if (wr_go || rd_go) begin
        wr_act <= wr_go;
        rd_act <= rd_go;
        cnt    <= wr_go ? POS_W'(1) : '0;
        mode_q <= qdr_mode;
        half_q <= half_sel;
        bank_q <= bank;
        row_q  <= open_row_q[bank];
        cl_q   <= col_lo;
        ch_q   <= col_hi;
      end else if (!idle) begin
        if (cnt == last) begin
          rd_act <= 1'b0;
          wr_act <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + POS_W'(1);
        end
      end
    end
  end

  assign rvalid = rd_act;
  assign busy   = !idle;
  assign err    = err_q;
  assign rdata  = rd_act ? {mem_hi[idx_hi], mem_lo[idx_lo]} : '0;
endmodule

module dual_lane_burst_mem_chk (
  input logic clk,
  input logic rst_n,
  input logic qdr_mode,
  input logic act_req,
  input logic pre_req,
  input logic rd_req,
  input logic wr_req,
  input logic rvalid,
  input logic busy,
  input logic err
);
  logic [4:0] run;
  logic       mode_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      mode_c <= 1'b0;
    end else begin
      run <= rvalid ? run + 5'd1 : 5'd0;
      if (rd_req && !act_req && !pre_req && !wr_req && !busy) mode_c <= qdr_mode;
    end
  end

  AST_BURST_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> run < (mode_c ? 5'd16 : 5'd8)); // R10

  AST_BURST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid) |-> $past(run) == (mode_c ? 5'd15 : 5'd7)); // R4

  AST_REJECT_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !rvalid); // R2

  AST_ERR_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_req || wr_req)); // R2

  AST_READ_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(rd_req) && $past(!busy)); // R8
endmodule

bind dual_lane_burst_mem dual_lane_burst_mem_chk chk_i (
  .clk(clk), .rst_n(rst_n), .qdr_mode(qdr_mode), .act_req(act_req),
  .pre_req(pre_req), .rd_req(rd_req), .wr_req(wr_req), .rvalid(rvalid),
  .busy(busy), .err(err)
);

// File: tb/dual_lane_burst_mem_tb.sv
`timescale 1ns/1ps
module dual_lane_burst_mem_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic qdr_mode = 1'b0, act_req = 1'b0, pre_req = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [1:0] bank = '0, row = '0, col_lo = '0, col_hi = '0;
  logic half_sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic rvalid, busy, err;

  always #2 clk = ~clk;

  dual_lane_burst_mem dut_i (
    .clk(clk), .rst_n(rst_n), .qdr_mode(qdr_mode), .act_req(act_req), .pre_req(pre_req),
    .rd_req(rd_req), .wr_req(wr_req), .bank(bank), .row(row), .col_lo(col_lo),
    .col_hi(col_hi), .half_sel(half_sel), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid), .busy(busy), .err(err)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [15:0] m_lo [1024];
  logic [15:0] m_hi [1024];
  bit v_lo [1024];
  bit v_hi [1024];
  bit bopen [4];
  int brow [4];
  logic [31:0] wbuf [16];

  function automatic int fidx(int b, int r, int c, int p);
    return ((b * 4 + r) * 4 + c) * 16 + p;
  endfunction

  function automatic int fpos(int q, int h, int k);
    return q ? k : h * 8 + k;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_act(int b, int r);
    act_req = 1; bank = 2'(b); row = 2'(r);
    @(negedge clk); act_req = 0;
    bopen[b] = 1; brow[b] = r;
  endtask

  task automatic do_pre(int b);
    pre_req = 1; bank = 2'(b);
    @(negedge clk); pre_req = 0;
    bopen[b] = 0;
  endtask

  task automatic fill(logic [31:0] base);
    for (int k = 0; k < 16; k++) wbuf[k] = base + 32'(k) * 32'h00010001;
  endtask

  task automatic fill_rand();
    for (int k = 0; k < 16; k++) wbuf[k] = $urandom;
  endtask

  task automatic write_burst(int b, int cl, int ch, int h, int q, bit inj_rd, string req);
    int n;
    n = q ? 16 : 8;
    bank = 2'(b); col_lo = 2'(cl); col_hi = 2'(ch); half_sel = h[0]; qdr_mode = q[0];
    for (int k = 0; k < n; k++) begin
      wdata = wbuf[k];
      wr_req = (k == 0);
      rd_req = inj_rd && (k == 4);
      if (bopen[b]) begin
        m_lo[fidx(b, brow[b], cl, fpos(q, h, k))] = wbuf[k][15:0];
        m_hi[fidx(b, brow[b], ch, fpos(q, h, k))] = wbuf[k][31:16];
        v_lo[fidx(b, brow[b], cl, fpos(q, h, k))] = 1;
        v_hi[fidx(b, brow[b], ch, fpos(q, h, k))] = 1;
      end
      @(negedge clk);
      wr_req = 0; rd_req = 0;
      if (k == 0) chk(err == !bopen[b], {req, " err on write request"}, 32'(err), 32'(!bopen[b]));
      if (inj_rd && k == 4) chk(!rvalid && !err, "R8 read while writing ignored", 32'(rvalid), 0);
      if (!bopen[b]) break;
    end
  endtask

  task automatic read_burst(int b, int cl, int ch, int h, int q, bit inj_wr, string req);
    int n;
    logic [31:0] exp, msk;
    n = q ? 16 : 8;
    bank = 2'(b); col_lo = 2'(cl); col_hi = 2'(ch); half_sel = h[0]; qdr_mode = q[0];
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    chk(busy == 1'b1, "R10 busy during read", 32'(busy), 1);
    for (int k = 0; k < n; k++) begin
      exp = '0; msk = '0;
      if (v_lo[fidx(b, brow[b], cl, fpos(q, h, k))]) begin
        exp[15:0] = m_lo[fidx(b, brow[b], cl, fpos(q, h, k))]; msk[15:0] = 16'hFFFF;
      end
      if (v_hi[fidx(b, brow[b], ch, fpos(q, h, k))]) begin
        exp[31:16] = m_hi[fidx(b, brow[b], ch, fpos(q, h, k))]; msk[31:16] = 16'hFFFF;
      end
      chk(rvalid && ((rdata & msk) == exp), $sformatf("%s beat %0d", req, k), rdata, exp);
      wr_req = inj_wr && (k == 3);
      wdata = 32'hBAD0BAD0;
      @(negedge clk);
      wr_req = 0;
      if (inj_wr && k == 3) chk(!err && rvalid, "R8 write while reading ignored", 32'(err), 0);
    end
    chk(!rvalid && rdata == 0, "R10 rvalid low after burst", rdata, 0);
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int b, cl, ch, h, q, r;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin v_lo[i] = 0; v_hi[i] = 0; end
    for (int i = 0; i < 4; i++) begin bopen[i] = 0; brow[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rvalid && !busy && !err && rdata == 0, "R1 reset state", {rvalid, busy, err}, 0);

    // R1 / R2: every bank closed after reset, read is refused
    bank = 2'd1; rd_req = 1;
    @(negedge clk); rd_req = 0;
    chk(err && !rvalid && !busy, "R2 read closed bank refused", {err, rvalid, busy}, 3'b100);
    @(negedge clk);
    chk(!err && !rvalid, "R2 err is one pulse", 32'(err), 0);

    // R2: refused write leaves array unchanged
    do_act(2, 1);
    fill(32'h11110000); write_burst(2, 0, 0, 0, 1, 0, "R3");
    do_pre(2);
    fill(32'hEEEE0000); write_burst(2, 0, 0, 0, 1, 0, "R2");
    do_act(2, 1);
    read_burst(2, 0, 0, 0, 1, 0, "R2 refused write left data");

    // R3: QDR round trip
    do_act(0, 2);
    fill(32'hA0000100); write_burst(0, 1, 1, 0, 1, 0, "R3");
    read_burst(0, 1, 1, 0, 1, 0, "R3 QDR readback");

    // R6: independent lane columns
    fill(32'hB0B00000); write_burst(0, 3, 2, 0, 1, 0, "R6");
    fill(32'hC0C01000); write_burst(0, 2, 3, 0, 1, 0, "R6");
    read_burst(0, 2, 3, 0, 1, 0, "R6 lanes cl2 ch3");
    read_burst(0, 3, 2, 0, 1, 0, "R6 lanes cl3 ch2");

    // R4 / R7: two DDR halves read as one QDR burst
    do_act(1, 3);
    fill(32'hD1000000); write_burst(1, 0, 1, 0, 0, 0, "R4");
    fill(32'hD2000000); write_burst(1, 0, 1, 1, 0, 0, "R4");
    read_burst(1, 0, 1, 0, 1, 0, "R7 DDR halves as QDR");
    read_burst(1, 0, 1, 1, 0, 0, "R4 DDR upper half");

    // R7 / R5: QDR write read as DDR halves, QDR ignores half_sel
    fill(32'hE1230000); write_burst(1, 2, 2, 1, 1, 0, "R5");
    read_burst(1, 2, 2, 0, 0, 0, "R7 QDR as DDR half0");
    read_burst(1, 2, 2, 1, 0, 0, "R7 QDR as DDR half1");
    read_burst(1, 2, 2, 1, 1, 0, "R5 QDR half_sel ignored");

    // R8: requests while busy
    fill(32'hF0F00000); write_burst(1, 3, 3, 0, 1, 1, "R8");
    read_burst(1, 3, 3, 0, 1, 1, "R8 read with write injected");
    read_burst(1, 3, 3, 0, 1, 0, "R8 data unchanged after injected write");

    // R9: re-activate switches row
    do_act(3, 0);
    fill(32'h30000000); write_burst(3, 1, 2, 0, 1, 0, "R9");
    do_act(3, 2);
    fill(32'h32000000); write_burst(3, 1, 2, 0, 1, 0, "R9");
    read_burst(3, 1, 2, 0, 1, 0, "R9 row 2 data");
    do_act(3, 0);
    read_burst(3, 1, 2, 0, 1, 0, "R9 row 0 data");

    // random mix
    for (int it = 0; it < 60; it++) begin
      b = $urandom_range(0, 3); r = $urandom_range(0, 3);
      cl = $urandom_range(0, 3); ch = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0 || !bopen[b]) do_act(b, r);
      q = $urandom_range(0, 1); h = $urandom_range(0, 1);
      fill_rand(); write_burst(b, cl, ch, h, q, 0, "R6 random");
      q = $urandom_range(0, 1); h = $urandom_range(0, 1);
      read_burst(b, cl, ch, h, q, 0, "R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule